// File: doc/BRIEF.md
# Exponential Backoff Retry Controller

This block sits next to a requester that keeps retrying a contended atomic operation, such as a compare-and-swap. It holds a backoff count. Each new atomic sequence sets the count to one. Every failed attempt that the requester reports makes the block wait for a time proportional to the count. When the wait ends, the block tells the requester it may retry. It then doubles the count, unless the count is already above a fixed ceiling.

Two wait styles are available, and a mode input picks one when each wait begins. The first is spin: a loop of fixed-length spin units, one unit per unit of count. The second is pause: a single request to an external pause-counter block. That request carries the whole wait in cycles, which is the count scaled up by a fixed shift. In a single-requester configuration backoff is switched off by a parameter. A failure then turns straight into a retry indication.

Top module: `backoff_retry_ctrl`

## Requirements
- R1: A start pulse (`op_start_i`) sets the backoff count to 1. The first wait after a start therefore lasts one spin unit (SPIN_LEN cycles) in spin mode, or requests `1 << PAUSE_SHIFT` cycles in pause mode.
- R2: In spin mode, a failure accepted at clock edge E with count C makes `retry_ready_o` high in the cycle after edge E + C*SPIN_LEN. After that wait the count becomes 2*C.
- R3: The count doubles only while it is less than or equal to LIMIT. Once it is above LIMIT it stays unchanged. With LIMIT = 8 the sequence of counts is 1, 2, 4, 8, 16, 16, ...
- R4: In pause mode, a failure accepted at edge E raises `pause_req_valid_o` for exactly one cycle, the cycle after E. In that cycle `pause_req_cycles_o` equals count << PAUSE_SHIFT. This is one request, not a series of unit-sized requests.
- R5: `retry_ready_o` is a single-cycle pulse. In pause mode it is high in the cycle after the edge that samples `pause_done_i`.
- R6: While a wait is in progress, the block ignores `op_fail_i`, `op_start_i` and `op_success_i`. Outside a pause wait it also ignores `pause_done_i`. Neither the length of the wait nor the next count changes.
- R7: `wait_mode_i` (0 = spin, 1 = pause) is sampled only on the edge that accepts a failure. Changing it during a wait has no effect on that wait.
- R8: `op_success_i` returns the block to idle. A failure seen while idle produces no request and no retry. The next start reloads the count to 1. Among pulses in the same cycle while armed, start takes precedence over success, and success over failure.
- R9: With ENABLE_BACKOFF = 0, a failure while armed gives `retry_ready_o` in the very next cycle. No wait takes place and no pause request is issued.
- R10: After reset the block is idle, and `retry_ready_o` and `pause_req_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start_i | input | 1 | Pulse: a new atomic sequence begins |
| op_fail_i | input | 1 | Pulse: the last attempt failed |
| op_success_i | input | 1 | Pulse: the sequence completed |
| wait_mode_i | input | 1 | Wait style: 0 spin, 1 pause |
| pause_done_i | input | 1 | Pulse from the pause-counter block: the pause has elapsed |
| retry_ready_o | output | 1 | One-cycle pulse: the requester may retry |
| pause_req_valid_o | output | 1 | One-cycle pulse: pause request |
| pause_req_cycles_o | output | CNT_W+PAUSE_SHIFT | Cycle amount of the pause request, where CNT_W = clog2(LIMIT)+2 |

## Verification
The bench builds the main instance with LIMIT = 8 and SPIN_LEN = 4. This brings the ceiling within five failures: the sixth wait shows the count frozen at 16, so a spin wait never exceeds 64 cycles and a pause request never exceeds 2048. PAUSE_SHIFT stays at its default of 7, so the scaled request amounts are the same ones full-size parameters would give for the same count. A second instance with ENABLE_BACKOFF = 0 covers the immediate-retry configuration.

// File: rtl/backoff_pkg.sv
// Package: shared types for the exponential backoff retry controller.
// Assumes: nothing beyond IEEE 1800-2017.
package backoff_pkg;

    // Controller state: idle, armed (sequence running), or waiting in one of two styles.
    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_ARMED = 2'd1,
        BK_SPIN  = 2'd2,
        BK_PAUSE = 2'd3
    } bk_state_t;

    // Wait style encoding on the mode input.
    typedef enum logic {
        WAIT_SPIN  = 1'b0,
        WAIT_PAUSE = 1'b1
    } wait_mode_t;

endpackage

// File: rtl/backoff_count_reg.sv
// Module: backoff_count_reg
// Holds the backoff count. A load sets the count to 1. An advance doubles
// the count unless it already exceeds LIMIT, in which case it holds.
// Assumes: load and advance never arrive together (the FSM guarantees it),
// and CNT_W can hold 2*LIMIT.
module backoff_count_reg #(
    parameter int LIMIT = 4096,
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_one_i,
    input  logic             advance_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic             above_ceiling;

    // Ceiling test: doubling stops only once the count is strictly above the limit.
    always_comb begin
        above_ceiling = (count_q > LIMIT_V);
    end

    // Count register: reload on start, conditional doubling after a wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= ONE_V;
        end else if (load_one_i) begin
            count_q <= ONE_V;
        end else if (advance_i && !above_ceiling) begin
            count_q <= count_q << 1;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/backoff_spin_timer.sv
// Module: backoff_spin_timer
// Runs a loop of spin units. Each unit is SPIN_LEN cycles, counted by an
// internal down-counter, and the number of units is given at arm time.
// done_o is high in the last cycle of the last unit.
// Assumes: iters_i is non-zero when arm_i is high, SPIN_LEN >= 2, and
// arm_i is not raised while the timer is running.
module backoff_spin_timer #(
    parameter int CNT_W    = 14,
    parameter int SPIN_LEN = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] iters_i,
    output logic             done_o
);
    localparam int              UNIT_W   = (SPIN_LEN > 1) ? $clog2(SPIN_LEN) : 1;
    localparam logic [UNIT_W-1:0] UNIT_TOP = UNIT_W'(SPIN_LEN - 1);

    logic              running_q;
    logic [UNIT_W-1:0] unit_q;
    logic [CNT_W-1:0]  iter_q;
    logic              unit_end;
    logic              last_unit;

    // Decode the end of the current unit and whether it is the final one.
    always_comb begin
        unit_end  = (unit_q == '0);
        last_unit = (iter_q == '0);
    end

    // Spin unit and iteration down-counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            unit_q    <= '0;
            iter_q    <= '0;
        end else if (arm_i) begin
            running_q <= 1'b1;
            unit_q    <= UNIT_TOP;
            iter_q    <= iters_i - CNT_W'(1);
        end else if (running_q) begin
            if (unit_end) begin
                if (last_unit) begin
                    running_q <= 1'b0;
                end else begin
                    iter_q <= iter_q - CNT_W'(1);
                    unit_q <= UNIT_TOP;
                end
            end else begin
                unit_q <= unit_q - UNIT_W'(1);
            end
        end
    end

    assign done_o = running_q && unit_end && last_unit;

endmodule

// File: rtl/backoff_fsm.sv
// Module: backoff_fsm
// Sequences one atomic retry sequence. It reloads the count on start, picks
// the wait style when a failure arrives, issues the pause request, raises
// the retry pulse and advances the count when a wait ends.
// Assumes: the inputs are single-cycle pulses, synchronous to clk.
module backoff_fsm
    import backoff_pkg::*;
#(
    parameter int CNT_W          = 14,
    parameter int PAUSE_W        = 21,
    parameter int PAUSE_SHIFT    = 7,
    parameter bit ENABLE_BACKOFF = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               fail_i,
    input  logic               success_i,
    input  logic               mode_i,
    input  logic               pause_done_i,
    input  logic               spin_done_i,
    input  logic [CNT_W-1:0]   count_i,
    output bk_state_t          state_o,
    output logic               load_one_o,
    output logic               advance_o,
    output logic               spin_arm_o,
    output logic               retry_o,
    output logic               pause_valid_o,
    output logic [PAUSE_W-1:0] pause_cycles_o
);
    bk_state_t          state_q, state_d;
    logic               retry_q, retry_d;
    logic               pause_valid_q;
    logic               issue_pause;
    logic [PAUSE_W-1:0] pause_cycles_q;
    logic               pause_end;

    // A pause ends on the done pulse, never in the cycle of the request itself.
    always_comb begin
        pause_end = pause_done_i && !pause_valid_q;
    end

    // Next-state and control decode.
    always_comb begin
        state_d     = state_q;
        load_one_o  = 1'b0;
        advance_o   = 1'b0;
        spin_arm_o  = 1'b0;
        issue_pause = 1'b0;
        retry_d     = 1'b0;
        unique case (state_q)
            BK_IDLE: begin
                if (start_i) begin
                    state_d    = BK_ARMED;
                    load_one_o = 1'b1;
                end
            end
            BK_ARMED: begin
                if (start_i) begin
                    load_one_o = 1'b1;
                end else if (success_i) begin
                    state_d = BK_IDLE;
                end else if (fail_i) begin
                    if (!ENABLE_BACKOFF) begin
                        retry_d = 1'b1;
                    end else if (wait_mode_t'(mode_i) == WAIT_PAUSE) begin
                        state_d     = BK_PAUSE;
                        issue_pause = 1'b1;
                    end else begin
                        state_d    = BK_SPIN;
                        spin_arm_o = 1'b1;
                    end
                end
            end
            BK_SPIN: begin
                if (spin_done_i) begin
                    state_d   = BK_ARMED;
                    retry_d   = 1'b1;
                    advance_o = 1'b1;
                end
            end
            BK_PAUSE: begin
                if (pause_end) begin
                    state_d   = BK_ARMED;
                    retry_d   = 1'b1;
                    advance_o = 1'b1;
                end
            end
            default: state_d = BK_IDLE;
        endcase
    end

    // State and registered pulse outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= BK_IDLE;
            retry_q       <= 1'b0;
            pause_valid_q <= 1'b0;
        end else begin
            state_q       <= state_d;
            retry_q       <= retry_d;
            pause_valid_q <= issue_pause;
        end
    end

    // Pause amount: the whole wait in one request, count scaled by the shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_cycles_q <= '0;
        end else if (issue_pause) begin
            pause_cycles_q <= PAUSE_W'(count_i) << PAUSE_SHIFT;
        end
    end

    assign state_o        = state_q;
    assign retry_o        = retry_q;
    assign pause_valid_o  = pause_valid_q;
    assign pause_cycles_o = pause_cycles_q;

endmodule

// File: rtl/backoff_retry_ctrl.sv
// Module: backoff_retry_ctrl (top)
// Exponential backoff retry controller for a requester of contended atomic
// operations. It ties together the count register, the sequencing FSM and,
// when backoff is enabled, the spin timer.
// Assumes: inputs are synchronous single-cycle pulses; LIMIT >= 1;
// SPIN_LEN >= 2; PAUSE_SHIFT >= 1.
module backoff_retry_ctrl
    import backoff_pkg::*;
#(
    parameter int LIMIT          = 4096,
    parameter int SPIN_LEN       = 128,
    parameter int PAUSE_SHIFT    = 7,
    parameter bit ENABLE_BACKOFF = 1'b1,
    localparam int CNT_W         = $clog2(LIMIT) + 2,
    localparam int PAUSE_W       = CNT_W + PAUSE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_start_i,
    input  logic               op_fail_i,
    input  logic               op_success_i,
    input  logic               wait_mode_i,
    input  logic               pause_done_i,
    output logic               retry_ready_o,
    output logic               pause_req_valid_o,
    output logic [PAUSE_W-1:0] pause_req_cycles_o
);
    bk_state_t        cur_state;
    logic [CNT_W-1:0] cur_count;
    logic             load_one;
    logic             advance;
    logic             spin_arm;
    logic             spin_done;

    backoff_count_reg #(
        .LIMIT (LIMIT),
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_one_i (load_one),
        .advance_i  (advance),
        .count_o    (cur_count)
    );

    backoff_fsm #(
        .CNT_W          (CNT_W),
        .PAUSE_W        (PAUSE_W),
        .PAUSE_SHIFT    (PAUSE_SHIFT),
        .ENABLE_BACKOFF (ENABLE_BACKOFF)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (op_start_i),
        .fail_i         (op_fail_i),
        .success_i      (op_success_i),
        .mode_i         (wait_mode_i),
        .pause_done_i   (pause_done_i),
        .spin_done_i    (spin_done),
        .count_i        (cur_count),
        .state_o        (cur_state),
        .load_one_o     (load_one),
        .advance_o      (advance),
        .spin_arm_o     (spin_arm),
        .retry_o        (retry_ready_o),
        .pause_valid_o  (pause_req_valid_o),
        .pause_cycles_o (pause_req_cycles_o)
    );

    // The spin timer exists only when backoff is enabled.
    generate
        if (ENABLE_BACKOFF) begin : g_spin
            backoff_spin_timer #(
                .CNT_W    (CNT_W),
                .SPIN_LEN (SPIN_LEN)
            ) u_spin (
                .clk     (clk),
                .rst_n   (rst_n),
                .arm_i   (spin_arm),
                .iters_i (cur_count),
                .done_o  (spin_done)
            );
        end else begin : g_nospin
            logic unused_spin_arm;
            assign unused_spin_arm = spin_arm;
            assign spin_done       = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/backoff_retry_ctrl_checker.sv
// Module: backoff_retry_ctrl_checker
// Protocol and state checks for backoff_retry_ctrl, attached through bind.
// Assumes: it is bound to backoff_retry_ctrl with the signals named below.
module backoff_retry_ctrl_checker
    import backoff_pkg::*;
#(
    parameter int LIMIT          = 4096,
    parameter int CNT_W          = 14,
    parameter int PAUSE_W        = 21,
    parameter int PAUSE_SHIFT    = 7,
    parameter bit ENABLE_BACKOFF = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_fail_i,
    input logic               retry_ready_o,
    input logic               pause_req_valid_o,
    input logic [PAUSE_W-1:0] pause_req_cycles_o,
    input bk_state_t          cur_state,
    input logic [CNT_W-1:0]   cur_count
);
    // R5: with backoff on, the retry indication lasts one cycle.
    assert_retry_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ENABLE_BACKOFF && retry_ready_o) |=> !retry_ready_o);

    // R4: the pause request is a single-cycle pulse.
    assert_pause_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req_valid_o |=> !pause_req_valid_o);

    // R4: the requested amount is a power of two scaled by the shift.
    assert_pause_scaled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req_valid_o |-> (pause_req_cycles_o[PAUSE_SHIFT-1:0] == '0
                               && $countones(pause_req_cycles_o) == 1));

    // R8: a failure while idle produces neither a request nor a retry.
    assert_idle_fail_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == BK_IDLE && op_fail_i) |=> (!retry_ready_o && !pause_req_valid_o));

    // R6: the count is frozen for as long as a wait continues.
    assert_count_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_state == BK_SPIN || cur_state == BK_PAUSE)
         && ($past(cur_state) == BK_SPIN || $past(cur_state) == BK_PAUSE))
        |-> $stable(cur_count));

    // R3: the count stays a power of two and never passes twice the ceiling.
    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state != BK_IDLE) |-> ($countones(cur_count) == 1
                                    && int'(cur_count) <= 2 * LIMIT));

endmodule

bind backoff_retry_ctrl backoff_retry_ctrl_checker #(
    .LIMIT          (LIMIT),
    .CNT_W          (CNT_W),
    .PAUSE_W        (PAUSE_W),
    .PAUSE_SHIFT    (PAUSE_SHIFT),
    .ENABLE_BACKOFF (ENABLE_BACKOFF)
) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .op_fail_i          (op_fail_i),
    .retry_ready_o      (retry_ready_o),
    .pause_req_valid_o  (pause_req_valid_o),
    .pause_req_cycles_o (pause_req_cycles_o),
    .cur_state          (cur_state),
    .cur_count          (cur_count)
);

// File: tb/backoff_retry_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard. Driver tasks push expected events; a monitor pops and
// compares them as the design raises pause requests and retry pulses.
module backoff_retry_ctrl_bench;
    localparam int B_LIMIT = 8;
    localparam int B_SPIN  = 4;
    localparam int B_SHIFT = 7;
    localparam int B_CNT_W = $clog2(B_LIMIT) + 2;
    localparam int B_PW    = B_CNT_W + B_SHIFT;
    localparam int K_RETRY = 0;
    localparam int K_PAUSE = 1;

    typedef struct {
        int     kind;
        longint val;
        string  tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, fail = 1'b0, succ = 1'b0, mode = 1'b0, pdone = 1'b0;
    logic retry, pvalid;
    logic [B_PW-1:0] pcycles;
    logic nb_start = 1'b0, nb_fail = 1'b0;
    logic nb_retry, nb_valid;
    logic [B_PW-1:0] nb_cycles;

    longint cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    backoff_retry_ctrl #(
        .LIMIT (B_LIMIT), .SPIN_LEN (B_SPIN), .PAUSE_SHIFT (B_SHIFT), .ENABLE_BACKOFF (1'b1)
    ) u_backoff_retry_ctrl (
        .clk (clk), .rst_n (rst_n), .op_start_i (start), .op_fail_i (fail),
        .op_success_i (succ), .wait_mode_i (mode), .pause_done_i (pdone),
        .retry_ready_o (retry), .pause_req_valid_o (pvalid), .pause_req_cycles_o (pcycles)
    );

    backoff_retry_ctrl #(
        .LIMIT (B_LIMIT), .SPIN_LEN (B_SPIN), .PAUSE_SHIFT (B_SHIFT), .ENABLE_BACKOFF (1'b0)
    ) u_nobk (
        .clk (clk), .rst_n (rst_n), .op_start_i (nb_start), .op_fail_i (nb_fail),
        .op_success_i (1'b0), .wait_mode_i (1'b1), .pause_done_i (1'b0),
        .retry_ready_o (nb_retry), .pause_req_valid_o (nb_valid), .pause_req_cycles_o (nb_cycles)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic take(input int kind, input longint val);
        exp_t e;
        if (q.size() == 0) begin
            check(1'b0, (kind == K_RETRY) ? "unexpected retry R6" : "unexpected pause R6",
                  val, -1);
        end else begin
            e = q.pop_front();
            check(e.kind == kind, {e.tag, " kind"}, kind, e.kind);
            check(e.val == val, e.tag, val, e.val);
        end
    endtask

    // Monitor: compare every design event with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (pvalid) take(K_PAUSE, longint'(pcycles));
            if (retry)  take(K_RETRY, cyc);
        end
    end

    task automatic drain(input string tag);
        int n = 0;
        while (q.size() != 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(q.size() == 0, {tag, " drain"}, q.size(), 0);
        q.delete();
    endtask

    // Spin-mode failure: expect a retry count*SPIN_LEN cycles after the accept edge.
    task automatic spin_try(input int cnt, input string tag, input bit disturb);
        exp_t e;
        e.kind = K_RETRY; e.val = cyc + 1 + cnt * B_SPIN; e.tag = tag;
        q.push_back(e);
        fail = 1'b1; mode = 1'b0;
        @(negedge clk);
        fail = 1'b0;
        if (disturb) begin
            // R6 / R7: pulses and a mode change mid-wait must not matter.
            repeat (2) @(negedge clk);
            fail = 1'b1; start = 1'b1; succ = 1'b1; pdone = 1'b1; mode = 1'b1;
            @(negedge clk);
            fail = 1'b0; start = 1'b0; succ = 1'b0; pdone = 1'b0;
        end
        drain(tag);
        mode = 1'b0;
    endtask

    // Pause-mode failure: expect one scaled request, then a retry after done.
    task automatic pause_try(input int cnt, input string tag);
        exp_t e;
        int n = 0;
        e.kind = K_PAUSE; e.val = longint'(cnt) << B_SHIFT; e.tag = {tag, " amount"};
        q.push_back(e);
        fail = 1'b1; mode = 1'b1;
        @(negedge clk);
        fail = 1'b0; mode = 1'b0;   // R7: mode flips during the pause wait
        while (q.size() != 0 && n < 10) begin
            @(negedge clk);
            n++;
        end
        check(q.size() == 0, {tag, " request seen"}, q.size(), 0);
        q.delete();
        repeat (2) @(negedge clk);
        fail = 1'b1;                // R6: ignored while pausing
        @(negedge clk);
        fail = 1'b0;
        @(negedge clk);
        e.kind = K_RETRY; e.val = cyc + 1; e.tag = {tag, " retry R5"};
        q.push_back(e);
        pdone = 1'b1;
        @(negedge clk);
        pdone = 1'b0;
        drain(tag);
    endtask

    task automatic finish_run();
        done_flag = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(retry == 1'b0, "R10 retry after reset", retry, 0);
        check(pvalid == 1'b0, "R10 pause valid after reset", pvalid, 0);
        check(nb_retry == 1'b0, "R10 no-backoff retry after reset", nb_retry, 0);

        // R1 / R2 / R3: spin waits 4, 8, 16, 32, 64, 64 cycles
        start = 1'b1; @(negedge clk); start = 1'b0;
        spin_try(1,  "R1 spin count 1", 1'b0);
        spin_try(2,  "R2 spin count 2 R6 R7", 1'b1);
        spin_try(4,  "R2 spin count 4", 1'b0);
        spin_try(8,  "R3 spin count 8", 1'b0);
        spin_try(16, "R3 spin count 16", 1'b1);
        spin_try(16, "R3 spin held at 16", 1'b0);

        // R8: success to idle, failure in idle ignored
        succ = 1'b1; @(negedge clk); succ = 1'b0;
        fail = 1'b1; pdone = 1'b1; @(negedge clk); fail = 1'b0; pdone = 1'b0;
        repeat (30) @(negedge clk);
        check(q.size() == 0 && retry == 1'b0, "R8 idle failure ignored", retry, 0);

        // R1 / R4: pause amounts 128, 256, 512, 1024, 2048, 2048
        start = 1'b1; @(negedge clk); start = 1'b0;
        pause_try(1,  "R1 R4 pause count 1");
        pause_try(2,  "R4 pause count 2");
        pause_try(4,  "R4 pause count 4");
        pause_try(8,  "R4 pause count 8");
        pause_try(16, "R3 pause count 16");
        pause_try(16, "R3 pause held at 16");

        // R8: a new start reloads the count to 1
        start = 1'b1; @(negedge clk); start = 1'b0;
        spin_try(1, "R8 reload after start", 1'b0);

        // R9: no backoff, immediate retry and no pause request
        nb_start = 1'b1; @(negedge clk); nb_start = 1'b0;
        nb_fail = 1'b1; @(negedge clk); nb_fail = 1'b0;
        check(nb_retry == 1'b1, "R9 immediate retry", nb_retry, 1);
        check(nb_valid == 1'b0, "R9 no pause request", nb_valid, 0);
        @(negedge clk);
        check(nb_retry == 1'b0, "R9 retry single cycle", nb_retry, 0);

        repeat (3) @(negedge clk);
        check(q.size() == 0, "final scoreboard empty", q.size(), 0);
        finish_run();
    end

endmodule